// File: doc/BRIEF.md
# USB Transceiver Line Interface with Eye-Pattern Generator

This block connects a USB serial interface engine to an external full- or low-speed transceiver chip. When the engine asks to transmit, the block pulls an active-low output enable and places the requested line state on a two-wire transmit code. The two single-ended receive wires from the transceiver are synchronised and decoded into a named bus-state code. A monitor output shows whether the block is driving the bus or listening to it.

For board bring-up the block has an eye-pattern test mode. In this mode the block switches itself to transmit and sends an endless alternating J/K sequence, one symbol per externally supplied bit-time pulse. The sequence starts with J at low speed and with K at full speed. When the test is switched off, the symbol in flight is completed before the output enable is released.

A four-state controller sets the transmit side. `ST_LISTEN` is the idle receive state. `ST_SIE_DRIVE` passes the engine's line codes to the transceiver. `ST_EYE_RUN` sends the test pattern. `ST_EYE_DRAIN` holds the last test symbol until the bit ends. Transitions:
- `ST_LISTEN` goes to `ST_EYE_RUN` when the block is enabled and the test bit is set. Otherwise it goes to `ST_SIE_DRIVE` when the block is enabled and a transmit request is present.
- `ST_SIE_DRIVE` goes to `ST_EYE_RUN` on an enabled test. It goes back to `ST_LISTEN` when the request or the enable drops.
- `ST_EYE_RUN` goes to `ST_EYE_DRAIN` when the test or the enable drops.
- `ST_EYE_DRAIN` goes back to `ST_EYE_RUN` if the test is enabled again. Otherwise it goes to `ST_LISTEN` on the next bit pulse.

Top module: `usbx_line_if`

## Requirements
- R1: After reset `xcvr_oe_n` is 1, `{xcvr_vpo,xcvr_vmo}` is 00, `tx_illegal` is 0 and `rx_bus_state` is 0 (SE0).
- R2: With `cfg_enable`=1 and `sie_tx_req`=1 sampled at a clock edge, after that edge `xcvr_oe_n` is 0 and `{xcvr_vpo,xcvr_vmo}` equals the `sie_tx_code` sampled at the same edge (00 SE0, 01 differential 0, 10 differential 1). With `cfg_enable`=0 the request is ignored: `xcvr_oe_n` stays 1 and the pair stays 00.
- R3: A requested code of 11 is never driven. While it is being transmitted the pair shows 00 and `tx_illegal` is 1. `tx_illegal` is 0 at all other times.
- R4: When `cfg_enable`=1 and `cfg_eye_test`=1 are sampled at an edge, after that edge `xcvr_oe_n` is 0 and the first test symbol is driven. A pending engine request does not override the test.
- R5: Symbol mapping: at full speed (`cfg_full_speed`=1) J is pair 10 and K is 01. At low speed J is 01 and K is 10. The first test symbol is K at full speed and J at low speed.
- R6: In test mode each edge that samples `bit_tick`=1 flips the symbol (J to K or K to J). The symbol holds on edges without a tick, and the pattern repeats for as long as the test stays on.
- R7: When `cfg_eye_test` drops, the current symbol stays driven with `xcvr_oe_n`=0 until an edge samples `bit_tick`=1. After that edge `xcvr_oe_n` is 1 and the pair is 00.
- R8: Receive decode of `{xcvr_vp,xcvr_vm}`: 00 gives `rx_bus_state` 0 (SE0), 10 gives 1 (full-speed idle), 01 gives 2 (low-speed idle), 11 gives 3 (error).
- R9: A change on the receive pins appears on `rx_bus_state` after the second clock edge that samples it, and not after the first.
- R10: `oe_mon_active` = `cfg_ext_xcvr` OR `cfg_oe_mon_on`. `oe_mon_driving` is 1 exactly when `oe_mon_active` is 1 and `xcvr_oe_n` is 0.
- R11: In engine transmit, an edge that samples `sie_tx_req`=0 (with no test enabled) releases `xcvr_oe_n` to 1 after that edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cfg_enable | input | 1 | Block enable |
| cfg_full_speed | input | 1 | 1 selects full speed, 0 selects low speed |
| cfg_ext_xcvr | input | 1 | An external transceiver is in use (turns the monitor on) |
| cfg_oe_mon_on | input | 1 | Forces the output-enable monitor on |
| cfg_eye_test | input | 1 | Eye-pattern test request |
| bit_tick | input | 1 | One pulse per bit time |
| sie_tx_req | input | 1 | Engine wants to drive the bus |
| sie_tx_code | input | 2 | Requested line code from the engine |
| xcvr_oe_n | output | 1 | Active-low transmit enable to the transceiver |
| xcvr_vpo | output | 1 | Transmit code, upper bit |
| xcvr_vmo | output | 1 | Transmit code, lower bit |
| xcvr_vp | input | 1 | Single-ended receive wire, upper bit |
| xcvr_vm | input | 1 | Single-ended receive wire, lower bit |
| rx_bus_state | output | 2 | Synchronised, decoded bus state |
| tx_illegal | output | 1 | An 11 request is being replaced by SE0 |
| oe_mon_active | output | 1 | The output-enable monitor is on |
| oe_mon_driving | output | 1 | Monitor reports that the block is driving |

## Verification
Every transmit-side result (enable, pair code, illegal flag, monitor) is due one edge after the inputs that cause it are sampled. Receive decodes are due two edges after the pins change. The bench changes inputs shortly after a rising edge and reads outputs just before the next change. It samples after exactly one edge for transmit checks, and after one and then two edges for receive checks, so the one-edge read shows the old value. The sweeps cover every engine code with the enable both on and off, every receive code, every monitor setting in both bus directions, and test-mode runs at both speeds that include tick/hold sequences, a drain and entry with a competing engine request.

// File: rtl/usbx_pkg.sv
package usbx_pkg;

    typedef enum logic [1:0] {
        LN_SE0   = 2'b00,
        LN_DIFF0 = 2'b01,
        LN_DIFF1 = 2'b10,
        LN_BAD   = 2'b11
    } line_code_e;

    typedef enum logic [1:0] {
        BUS_SE0     = 2'd0,
        BUS_FS_IDLE = 2'd1,
        BUS_LS_IDLE = 2'd2,
        BUS_ERROR   = 2'd3
    } bus_state_e;

    typedef enum logic [1:0] {
        ST_LISTEN,
        ST_SIE_DRIVE,
        ST_EYE_RUN,
        ST_EYE_DRAIN
    } ctl_state_e;

endpackage

// File: rtl/usbx_ctrl_fsm.sv
module usbx_ctrl_fsm
    import usbx_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       cfg_enable,
    input  logic       cfg_eye_test,
    input  logic       sie_tx_req,
    input  logic       bit_tick,
    output ctl_state_e state_q,
    output logic       eye_load,
    output logic       eye_step
);

    ctl_state_e state_d;
    logic       eye_on;
    logic       sie_on;

    assign eye_on = cfg_enable & cfg_eye_test;
    assign sie_on = cfg_enable & sie_tx_req;

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_LISTEN;
        end else begin
            state_q <= state_d;
        end
    end

    // next-state decision
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_LISTEN: begin
                if (eye_on) begin
                    state_d = ST_EYE_RUN;
                end else if (sie_on) begin
                    state_d = ST_SIE_DRIVE;
                end
            end
            ST_SIE_DRIVE: begin
                if (eye_on) begin
                    state_d = ST_EYE_RUN;
                end else if (!sie_on) begin
                    state_d = ST_LISTEN;
                end
            end
            ST_EYE_RUN: begin
                if (!eye_on) begin
                    state_d = ST_EYE_DRAIN;
                end
            end
            ST_EYE_DRAIN: begin
                if (eye_on) begin
                    state_d = ST_EYE_RUN;
                end else if (bit_tick) begin
                    state_d = ST_LISTEN;
                end
            end
            default: state_d = ST_LISTEN;
        endcase
    end

    // control strobes for the pattern generator
    always_comb begin
        eye_load = 1'b0;
        eye_step = 1'b0;
        unique case (state_q)
            ST_LISTEN, ST_SIE_DRIVE: eye_load = (state_d == ST_EYE_RUN);
            ST_EYE_RUN:              eye_step = bit_tick;
            ST_EYE_DRAIN:            eye_step = 1'b0;
            default:                 eye_step = 1'b0;
        endcase
    end

    AST_DRAIN_EXIT: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_EYE_DRAIN && bit_tick && !eye_on) |=> (state_q == ST_LISTEN)); // R7

    AST_EYE_PRIORITY: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_LISTEN && eye_on) |=> (state_q == ST_EYE_RUN)); // R4

endmodule

// File: rtl/usbx_eye_gen.sv
module usbx_eye_gen (
    input  logic clk,
    input  logic rst_n,
    input  logic load,
    input  logic step,
    input  logic first_is_k,
    output logic sym_k
);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sym_k <= 1'b0;
        end else if (load) begin
            sym_k <= first_is_k;
        end else if (step) begin
            sym_k <= ~sym_k;
        end
    end

    AST_EYE_TOGGLE: assert property (@(posedge clk) disable iff (!rst_n)
        (step && !load) |=> (sym_k != $past(sym_k))); // R6

endmodule

// File: rtl/usbx_line_enc.sv
module usbx_line_enc
    import usbx_pkg::*;
(
    input  ctl_state_e state_q,
    input  logic [1:0] sie_code_q,
    input  logic       sym_k,
    input  logic       full_speed,
    output logic       oe_n,
    output logic [1:0] pair,
    output logic       illegal
);

    logic [1:0] j_code;
    logic [1:0] k_code;
    logic [1:0] eye_code;

    assign j_code   = full_speed ? LN_DIFF1 : LN_DIFF0;
    assign k_code   = full_speed ? LN_DIFF0 : LN_DIFF1;
    assign eye_code = sym_k ? k_code : j_code;

    always_comb begin
        oe_n    = 1'b1;
        pair    = LN_SE0;
        illegal = 1'b0;
        unique case (state_q)
            ST_LISTEN: begin
                oe_n = 1'b1;
            end
            ST_SIE_DRIVE: begin
                oe_n = 1'b0;
                if (sie_code_q == LN_BAD) begin
                    pair    = LN_SE0;
                    illegal = 1'b1;
                end else begin
                    pair = sie_code_q;
                end
            end
            ST_EYE_RUN, ST_EYE_DRAIN: begin
                oe_n = 1'b0;
                pair = eye_code;
            end
            default: oe_n = 1'b1;
        endcase
    end

endmodule

// File: rtl/usbx_rx_sync.sv
module usbx_rx_sync
    import usbx_pkg::*;
#(
    parameter int STAGES = 2
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       vp,
    input  logic       vm,
    output logic [1:0] bus_state
);

    logic [1:0] decoded;
    logic [1:0] sync_q [STAGES];

    always_comb begin
        unique case ({vp, vm})
            2'b00:   decoded = BUS_SE0;
            2'b10:   decoded = BUS_FS_IDLE;
            2'b01:   decoded = BUS_LS_IDLE;
            default: decoded = BUS_ERROR;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sync_q[0] <= BUS_SE0;
        end else begin
            sync_q[0] <= decoded;
        end
    end

    for (genvar s = 1; s < STAGES; s++) begin : g_stage
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                sync_q[s] <= BUS_SE0;
            end else begin
                sync_q[s] <= sync_q[s-1];
            end
        end
    end

    assign bus_state = sync_q[STAGES-1];

    AST_RX_FIRST_STAGE: assert property (@(posedge clk) disable iff (!rst_n)
        ({vp, vm} == 2'b11) |=> (sync_q[0] == BUS_ERROR)); // R8

endmodule

// File: rtl/usbx_line_if.sv
module usbx_line_if
    import usbx_pkg::*;
#(
    parameter int RX_SYNC_STAGES = 2,
    parameter int CODE_W         = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cfg_enable,
    input  logic              cfg_full_speed,
    input  logic              cfg_ext_xcvr,
    input  logic              cfg_oe_mon_on,
    input  logic              cfg_eye_test,
    input  logic              bit_tick,
    input  logic              sie_tx_req,
    input  logic [CODE_W-1:0] sie_tx_code,
    output logic              xcvr_oe_n,
    output logic              xcvr_vpo,
    output logic              xcvr_vmo,
    input  logic              xcvr_vp,
    input  logic              xcvr_vm,
    output logic [1:0]        rx_bus_state,
    output logic              tx_illegal,
    output logic              oe_mon_active,
    output logic              oe_mon_driving
);

    ctl_state_e        state_q;
    logic              eye_load;
    logic              eye_step;
    logic              sym_k;
    logic [CODE_W-1:0] sie_code_q;
    logic [1:0]        pair;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sie_code_q <= '0;
        end else begin
            sie_code_q <= sie_tx_code;
        end
    end

    usbx_ctrl_fsm i_fsm (
        .clk          (clk),
        .rst_n        (rst_n),
        .cfg_enable   (cfg_enable),
        .cfg_eye_test (cfg_eye_test),
        .sie_tx_req   (sie_tx_req),
        .bit_tick     (bit_tick),
        .state_q      (state_q),
        .eye_load     (eye_load),
        .eye_step     (eye_step)
    );

    usbx_eye_gen i_eye (
        .clk        (clk),
        .rst_n      (rst_n),
        .load       (eye_load),
        .step       (eye_step),
        .first_is_k (cfg_full_speed),
        .sym_k      (sym_k)
    );

    usbx_line_enc i_enc (
        .state_q    (state_q),
        .sie_code_q (sie_code_q[1:0]),
        .sym_k      (sym_k),
        .full_speed (cfg_full_speed),
        .oe_n       (xcvr_oe_n),
        .pair       (pair),
        .illegal    (tx_illegal)
    );

    usbx_rx_sync #(.STAGES(RX_SYNC_STAGES)) i_rx (
        .clk       (clk),
        .rst_n     (rst_n),
        .vp        (xcvr_vp),
        .vm        (xcvr_vm),
        .bus_state (rx_bus_state)
    );

    assign xcvr_vpo       = pair[1];
    assign xcvr_vmo       = pair[0];
    assign oe_mon_active  = cfg_ext_xcvr | cfg_oe_mon_on;
    assign oe_mon_driving = oe_mon_active & ~xcvr_oe_n;

    AST_NO_BAD_LINE: assert property (@(posedge clk) disable iff (!rst_n)
        !(xcvr_vpo && xcvr_vmo)); // R3

    AST_EYE_DRIVES: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_EYE_RUN) |-> !xcvr_oe_n); // R4

    AST_LISTEN_RELEASED: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_LISTEN) |-> (xcvr_oe_n && !tx_illegal)); // R1

    AST_REQ_DROP: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_SIE_DRIVE && !sie_tx_req && !cfg_eye_test) |=> xcvr_oe_n); // R11

    AST_MON_GATED: assert property (@(posedge clk) disable iff (!rst_n)
        !oe_mon_active |-> !oe_mon_driving); // R10

    AST_EYE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_EYE_RUN && !bit_tick && cfg_enable && cfg_eye_test
         && $stable(cfg_full_speed)) |=> $stable(pair)); // R6

endmodule

// File: tb/test_usbx_line_if.sv
module test_usbx_line_if;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       cfg_enable = 1'b0;
    logic       cfg_full_speed = 1'b0;
    logic       cfg_ext_xcvr = 1'b0;
    logic       cfg_oe_mon_on = 1'b0;
    logic       cfg_eye_test = 1'b0;
    logic       bit_tick = 1'b0;
    logic       sie_tx_req = 1'b0;
    logic [1:0] sie_tx_code = 2'b00;
    logic       xcvr_oe_n;
    logic       xcvr_vpo;
    logic       xcvr_vmo;
    logic       xcvr_vp = 1'b0;
    logic       xcvr_vm = 1'b0;
    logic [1:0] rx_bus_state;
    logic       tx_illegal;
    logic       oe_mon_active;
    logic       oe_mon_driving;

    int  n_tests = 0;
    int  n_fail  = 0;
    bit  done    = 1'b0;

    always #4 clk = ~clk;

    usbx_line_if i_usbx_line_if (
        .clk            (clk),
        .rst_n          (rst_n),
        .cfg_enable     (cfg_enable),
        .cfg_full_speed (cfg_full_speed),
        .cfg_ext_xcvr   (cfg_ext_xcvr),
        .cfg_oe_mon_on  (cfg_oe_mon_on),
        .cfg_eye_test   (cfg_eye_test),
        .bit_tick       (bit_tick),
        .sie_tx_req     (sie_tx_req),
        .sie_tx_code    (sie_tx_code),
        .xcvr_oe_n      (xcvr_oe_n),
        .xcvr_vpo       (xcvr_vpo),
        .xcvr_vmo       (xcvr_vmo),
        .xcvr_vp        (xcvr_vp),
        .xcvr_vm        (xcvr_vm),
        .rx_bus_state   (rx_bus_state),
        .tx_illegal     (tx_illegal),
        .oe_mon_active  (oe_mon_active),
        .oe_mon_driving (oe_mon_driving)
    );

    task automatic tick();
        @(posedge clk);
        #2;
    endtask

    task automatic check(input string req, input logic [3:0] act, input logic [3:0] exp);
        n_tests++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    // Pair code for J or K at a given speed
    function automatic logic [1:0] sym_code(input logic fs, input logic is_k);
        logic [1:0] j;
        j = fs ? 2'b10 : 2'b01;
        return is_k ? ~j : j;
    endfunction

    function automatic logic [1:0] rx_expect(input logic [1:0] pins);
        case (pins)
            2'b00:   return 2'd0;
            2'b10:   return 2'd1;
            2'b01:   return 2'd2;
            default: return 2'd3;
        endcase
    endfunction

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            n_fail++;
            n_tests++;
            $display("FAIL watchdog: actual running expected finished");
            $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end

    initial begin
        logic [1:0] prev_rx;
        logic       cur_k;
        logic [1:0] e_pair;
        repeat (3) tick();
        // R1 reset state
        check("R1 oe_n", {3'b0, xcvr_oe_n}, 4'd1);
        check("R1 pair", {2'b0, xcvr_vpo, xcvr_vmo}, 4'd0);
        check("R1 illegal", {3'b0, tx_illegal}, 4'd0);
        check("R1 rx", {2'b0, rx_bus_state}, 4'd0);
        rst_n = 1'b1;
        tick();

        // R2 R3 R11 R10: engine transmit sweep over enable, code and monitor settings
        for (int en = 0; en < 2; en++) begin
            for (int code = 0; code < 4; code++) begin
                for (int mon = 0; mon < 4; mon++) begin
                    cfg_enable    = en[0];
                    cfg_ext_xcvr  = mon[0];
                    cfg_oe_mon_on = mon[1];
                    sie_tx_req    = 1'b1;
                    sie_tx_code   = code[1:0];
                    tick();
                    e_pair = (en == 0 || code == 3) ? 2'b00 : code[1:0];
                    check("R2 oe_n", {3'b0, xcvr_oe_n}, {3'b0, (en == 0)});
                    check("R2 pair", {2'b0, xcvr_vpo, xcvr_vmo}, {2'b0, e_pair});
                    check("R3 illegal", {3'b0, tx_illegal}, {3'b0, (en == 1 && code == 3)});
                    check("R10 active", {3'b0, oe_mon_active}, {3'b0, (mon != 0)});
                    check("R10 driving", {3'b0, oe_mon_driving}, {3'b0, (mon != 0 && en == 1)});
                    sie_tx_req = 1'b0;
                    tick();
                    check("R11 release", {3'b0, xcvr_oe_n}, 4'd1);
                    check("R10 idle", {3'b0, oe_mon_driving}, 4'd0);
                    check("R3 idle flag", {3'b0, tx_illegal}, 4'd0);
                end
            end
        end

        // R8 R9: receive decode sweep, all transitions
        prev_rx = rx_bus_state;
        for (int a = 0; a < 4; a++) begin
            for (int b = 0; b < 4; b++) begin
                {xcvr_vp, xcvr_vm} = a[1:0];
                tick(); tick();
                prev_rx = rx_expect(a[1:0]);
                {xcvr_vp, xcvr_vm} = b[1:0];
                tick();
                check("R9 one edge", {2'b0, rx_bus_state}, {2'b0, prev_rx});
                tick();
                check("R8 decode", {2'b0, rx_bus_state}, {2'b0, rx_expect(b[1:0])});
            end
        end

        // R4 R5 R6 R7: eye pattern at both speeds
        for (int fs = 0; fs < 2; fs++) begin
            cfg_full_speed = fs[0];
            cfg_enable     = 1'b1;
            cfg_eye_test   = 1'b1;
            sie_tx_req     = 1'b1;
            sie_tx_code    = fs[0] ? 2'b01 : 2'b10;
            tick();
            cur_k = fs[0];
            check("R4 oe_n", {3'b0, xcvr_oe_n}, 4'd0);
            check("R5 first", {2'b0, xcvr_vpo, xcvr_vmo}, {2'b0, sym_code(fs[0], cur_k)});
            sie_tx_req = 1'b0;
            for (int i = 0; i < 6; i++) begin
                bit_tick = 1'b1;
                tick();
                bit_tick = 1'b0;
                cur_k = ~cur_k;
                check("R6 toggle", {2'b0, xcvr_vpo, xcvr_vmo}, {2'b0, sym_code(fs[0], cur_k)});
                tick(); tick();
                check("R6 hold", {2'b0, xcvr_vpo, xcvr_vmo}, {2'b0, sym_code(fs[0], cur_k)});
            end
            cfg_eye_test = 1'b0;
            tick(); tick();
            check("R7 drain oe", {3'b0, xcvr_oe_n}, 4'd0);
            check("R7 drain sym", {2'b0, xcvr_vpo, xcvr_vmo}, {2'b0, sym_code(fs[0], cur_k)});
            bit_tick = 1'b1;
            tick();
            bit_tick = 1'b0;
            check("R7 release", {3'b0, xcvr_oe_n}, 4'd1);
            check("R7 pair", {2'b0, xcvr_vpo, xcvr_vmo}, 4'd0);
        end

        // R4: test request ignored while block disabled
        cfg_enable   = 1'b0;
        cfg_eye_test = 1'b1;
        tick(); tick();
        check("R4 disabled", {3'b0, xcvr_oe_n}, 4'd1);
        cfg_eye_test = 1'b0;
        tick();

        done = 1'b1;
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

endmodule